// File: doc/BRIEF.md
# Dual Down-Counter Register Wrapper

This block places two independent down-counting timers behind a single 4 KB register window. A request on the bus side carries an address, a direction and write data. The low part of the window is split into two 32-byte slots, one per timer, and the offset inside each slot is handed to the timer with the slot base removed. The last eight words of the window form a read-only identification table. The two integration-test words near the top of the window read as zero. Every other location reads as zero and discards writes.

Each timer advances only on its own tick-enable input, so the two can run at different rates (nominally 1 MHz each). A timer keeps a load value, a current count, an 8-bit control word and a raw interrupt flag. Both timers' masked interrupts are merged onto one interrupt line. The request side takes no back-pressure: a request presented with `req_valid` high is accepted in that cycle. A read returns its data on `rsp_rdata` one cycle later, qualified by a single-cycle `rsp_valid`. There is no ready on the response side, so the consumer must capture it in that cycle.

Timer slot layout, as word index within a slot: 0 load (writing it also reloads the count), 1 current count (read only), 2 control, 3 interrupt clear (write only), 4 raw flag, 5 masked flag, 6 background load (sets the load value without touching the count). Control bits: 7 run, 6 periodic, 5 interrupt enable, 3:2 prescale (0 = every tick, 1 = every 16th, 2 = every 256th), 1 wide (32-bit free-run wrap), 0 single-shot.

Top module: `dual_timer_wrap`

## Requirements
- R1: Word offsets 0x00 to 0x1F reach timer 0 unchanged. For example, 0x18 reads timer 0's load value.
- R2: Offsets 0x20 to 0x3F reach timer 1 with 0x20 subtracted. For example, 0x24 reads timer 1's count and 0x38 reads its load value.
- R3: Reads of 0xFE0, 0xFE4 … 0xFFC return the bytes 0x04, 0x18, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in address order, in bits 7:0, with bits 31:8 zero.
- R4: `irq` is high exactly when at least one timer has its raw flag set and its interrupt-enable bit (control bit 5) set.
- R5: Offsets 0xF00 and 0xF04 read as zero, and writes to them change nothing.
- R6: Writes at offset 0x40 and above change no timer state. Reads of any offset that is not a timer register or an identification word return zero.
- R7: Address bits 31:12 are ignored, so an address aliases its low 12 bits for both reads and writes.
- R8: An access whose address bits 1:0 are not zero is not decoded. The read returns zero and the write changes nothing.
- R9: `rsp_valid` pulses for exactly one cycle, in the cycle after each accepted read and never after a write, with the read data on `rsp_rdata` in that cycle.
- R10: A running timer's count changes only on cycles where its own tick input is high (or on a load write). The other timer's tick has no effect on it.
- R11: After reset, each control word reads 0x20, each count and load value reads 0, `irq` is low and `rsp_valid` is low.
- R12: When a counting step finds the count at zero, the raw flag is set. The masked flag reads raw AND interrupt-enable. Any write to the clear word clears the raw flag.
- R13: In periodic mode, the step that finds zero reloads the count from the load value. A background-load write changes the load value only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; always accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address; bits 11:0 decoded |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_rdata | output | 32 | Registered read data |
| tick0 | input | 1 | Count enable for timer 0 |
| tick1 | input | 1 | Count enable for timer 1 |
| irq | output | 1 | OR of both timers' masked interrupts |

## Verification
The bench drives known values into load and control registers through aliased and rebased addresses, then reads them back. Because of this, a decoder that misroutes a slot or ignores an offset bit shows up on the next read, one cycle later. A count or raw flag that moves when it should not shows up on `irq` in the same cycle as the tick that caused it. It also shows up on the next count read. A response strobe raised after a write, or missing after a read, is visible in the very next cycle.

// File: rtl/dtw_pkg.sv
package dtw_pkg;

  // control word bit positions
  localparam int CTL_ONESHOT  = 0;
  localparam int CTL_WIDE     = 1;
  localparam int CTL_DIV_LO   = 2;
  localparam int CTL_IE       = 5;
  localparam int CTL_PERIODIC = 6;
  localparam int CTL_RUN      = 7;
  localparam logic [7:0] CTL_RESET = 8'h20;

  // word index within a timer slot
  typedef enum logic [2:0] {
    TR_LOAD   = 3'd0,
    TR_COUNT  = 3'd1,
    TR_CTRL   = 3'd2,
    TR_ICLR   = 3'd3,
    TR_RAW    = 3'd4,
    TR_MASKED = 3'd5,
    TR_BGLOAD = 3'd6
  } tmr_reg_e;

  // identification byte for the top eight words of the window
  function automatic logic [7:0] ident_byte(input logic [2:0] idx);
    logic [7:0] b;
    case (idx)
      3'd0:    b = 8'h04;
      3'd1:    b = 8'h18;
      3'd2:    b = 8'h14;
      3'd3:    b = 8'h00;
      3'd4:    b = 8'h0D;
      3'd5:    b = 8'hF0;
      3'd6:    b = 8'h05;
      default: b = 8'hB1;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/dtw_decode.sv
module dtw_decode #(
  parameter int NT       = 2,
  parameter int WIN_W    = 12,
  parameter int STRIDE_W = 5
) (
  input  logic [WIN_W-1:0]    addr,
  output logic [NT-1:0]       tmr_sel,
  output logic [2:0]          reg_idx,
  output logic                id_hit,
  output logic [2:0]          id_idx
);
  localparam int HI_W = WIN_W - STRIDE_W;
  localparam logic [HI_W-1:0] ID_SLOT = {HI_W{1'b1}};

  logic aligned;
  logic [HI_W-1:0] slot;

  assign aligned = (addr[1:0] == 2'b00);
  assign slot    = addr[WIN_W-1:STRIDE_W];
  assign reg_idx = addr[STRIDE_W-1:2];
  assign id_idx  = addr[STRIDE_W-1:2];
  assign id_hit  = aligned && (slot == ID_SLOT);

  for (genvar i = 0; i < NT; i++) begin : g_sel
    assign tmr_sel[i] = aligned && (slot == HI_W'(i));
  end
endmodule

// File: rtl/dtw_prescale.sv
module dtw_prescale #(
  parameter int PRE_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       run,
  input  logic [1:0] div,
  input  logic       clr,
  output logic       step
);
  logic [PRE_W-1:0] pc;
  logic wrap16, wrap256;

  always_ff @(posedge clk) begin
    if (!rst_n)            pc <= '0;
    else if (clr)          pc <= '0;
    else if (tick && run)  pc <= pc + 1'b1;
  end

  assign wrap16  = (pc[3:0] == 4'hF);
  assign wrap256 = (pc == {PRE_W{1'b1}});

  always_comb begin
    step = 1'b0;
    if (tick && run) begin
      case (div)
        2'd0:    step = 1'b1;
        2'd2:    step = wrap256;
        default: step = wrap16;
      endcase
    end
  end
endmodule

// File: rtl/dtw_timer.sv
module dtw_timer
  import dtw_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       reg_idx,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] rdata,
  input  logic             tick,
  output logic             irq,
  output logic             raw_o
);
  localparam logic [CNT_W-1:0] MAX_WIDE   = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] MAX_NARROW = CNT_W'(16'hFFFF);

  logic [7:0]       ctrl;
  logic [CNT_W-1:0] limit, count, mask;
  logic             raw, step, expire;
  logic             wr_load, wr_ctrl, wr_iclr, wr_bg;

  assign wr_load = wr_en && (reg_idx == TR_LOAD);
  assign wr_ctrl = wr_en && (reg_idx == TR_CTRL);
  assign wr_iclr = wr_en && (reg_idx == TR_ICLR);
  assign wr_bg   = wr_en && (reg_idx == TR_BGLOAD);
  assign mask    = ctrl[CTL_WIDE] ? MAX_WIDE : MAX_NARROW;
  assign expire  = step && (count == '0);

  dtw_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick),
    .run  (ctrl[CTL_RUN]),
    .div  (ctrl[CTL_DIV_LO+1:CTL_DIV_LO]),
    .clr  (wr_ctrl),
    .step (step)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl  <= CTL_RESET;
      limit <= '0;
      count <= '0;
      raw   <= 1'b0;
    end else begin
      if (step) begin
        if (count == '0) begin
          raw <= 1'b1;
          if (ctrl[CTL_ONESHOT])       ctrl[CTL_RUN] <= 1'b0;
          else if (ctrl[CTL_PERIODIC]) count <= limit & mask;
          else                         count <= mask;
        end else begin
          count <= (count - 1'b1) & mask;
        end
      end
      if (wr_load) begin
        limit <= wdata;
        count <= wdata;
      end
      if (wr_bg)   limit <= wdata;
      if (wr_ctrl) ctrl  <= wdata[7:0];
      if (wr_iclr && !expire) raw <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    case (reg_idx)
      TR_LOAD, TR_BGLOAD: rdata = limit;
      TR_COUNT:           rdata = count;
      TR_CTRL:            rdata = CNT_W'(ctrl);
      TR_RAW:             rdata = CNT_W'(raw);
      TR_MASKED:          rdata = CNT_W'(raw && ctrl[CTL_IE]);
      default:            rdata = '0;
    endcase
  end

  assign irq   = raw && ctrl[CTL_IE];
  assign raw_o = raw;

  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_load) |=> $stable(count)); // R10
  AST_CLEAR_DROPS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_iclr && !tick) |=> !raw); // R12
  AST_RELOAD_FROM_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && ctrl[CTL_PERIODIC] && !ctrl[CTL_ONESHOT] && !wr_en) |=> (count == ($past(limit) & $past(mask)))); // R13
endmodule

// File: rtl/dual_timer_wrap.sv
module dual_timer_wrap
  import dtw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int PRE_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              tick0,
  input  logic              tick1,
  output logic              irq
);
  localparam int NT       = 2;
  localparam int WIN_W    = 12;
  localparam int STRIDE_W = 5;

  logic [WIN_W-1:0]  win_addr;
  logic              unused_addr_hi;
  logic [NT-1:0]     tmr_sel, t_wr, t_irq, t_raw, tick_v;
  logic [2:0]        reg_idx, id_idx;
  logic              id_hit, rd_req;
  logic [DATA_W-1:0] t_rdata [NT];
  logic [DATA_W-1:0] rd_next;

  assign win_addr       = req_addr[WIN_W-1:0];
  assign unused_addr_hi = ^req_addr[ADDR_W-1:WIN_W];
  assign tick_v         = {tick1, tick0};
  assign rd_req         = req_valid && !req_write;

  dtw_decode #(.NT(NT), .WIN_W(WIN_W), .STRIDE_W(STRIDE_W)) u_dec (
    .addr   (win_addr),
    .tmr_sel(tmr_sel),
    .reg_idx(reg_idx),
    .id_hit (id_hit),
    .id_idx (id_idx)
  );

  for (genvar i = 0; i < NT; i++) begin : g_tmr
    assign t_wr[i] = req_valid && req_write && tmr_sel[i];
    dtw_timer #(.CNT_W(DATA_W), .PRE_W(PRE_W)) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (t_wr[i]),
      .reg_idx(reg_idx),
      .wdata  (req_wdata),
      .rdata  (t_rdata[i]),
      .tick   (tick_v[i]),
      .irq    (t_irq[i]),
      .raw_o  (t_raw[i])
    );
  end

  always_comb begin
    rd_next = '0;
    if (id_hit) rd_next = DATA_W'(ident_byte(id_idx));
    for (int i = 0; i < NT; i++) begin
      if (tmr_sel[i]) rd_next = rd_next | t_rdata[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_req;
      if (rd_req) rsp_rdata <= rd_next;
    end
  end

  assign irq = |t_irq;

  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(rd_req)); // R9
  AST_READ_GIVES_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rsp_valid); // R9
  AST_ID_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && win_addr[WIN_W-1:STRIDE_W] == '1 && win_addr[1:0] == 2'b00) |=> (rsp_rdata[DATA_W-1:8] == '0)); // R3
  AST_TEST_WORDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && (win_addr == 12'hF00 || win_addr == 12'hF04)) |=> (rsp_rdata == '0)); // R5
  AST_HIGH_WRITE_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && win_addr[WIN_W-1:6] != '0) |-> (t_wr == '0)); // R6
  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (t_raw != '0)); // R4
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tmr_sel, id_hit})); // R6
endmodule

// File: tb/dual_timer_wrap_tb.sv
module dual_timer_wrap_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        tick0 = 1'b0;
  logic        tick1 = 1'b0;
  logic        irq;

  int n_vec = 0;
  int n_bad = 0;
  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic [7:0]  id_tab [8] = '{8'h04, 8'h18, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

  always #2.5 clk = ~clk;

  dual_timer_wrap u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .tick0(tick0), .tick1(tick1), .irq(irq)
  );

  // monitor: pops expected read data when the response appears
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      n_vec++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R9 unexpected rsp_valid: actual 1 expected 0");
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rsp_rdata !== e) begin
          n_bad++;
          $display("FAIL %s: actual %h expected %h", t, rsp_rdata, e);
        end
      end
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string t);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  task automatic rd(input logic [31:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic pulse(input int which, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (which == 0) tick0 = 1'b1; else tick1 = 1'b1;
      @(negedge clk);
      tick0 = 1'b0; tick1 = 1'b0;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({31'd0, irq}, 32'd0, "R11 irq after reset");
    chk({31'd0, rsp_valid}, 32'd0, "R11 rsp_valid after reset");
    rd(32'h008, 32'h20, "R11 timer0 control reset");
    rd(32'h028, 32'h20, "R11 timer1 control reset");
    rd(32'h004, 32'h0,  "R11 timer0 count reset");
    rd(32'h020, 32'h0,  "R11 timer1 load reset");

    for (int i = 0; i < 8; i++) rd(32'hFE0 + 32'(4*i), {24'd0, id_tab[i]}, "R3 ident word");
    rd(32'hFE2, 32'h0, "R8 unaligned ident read");
    rd(32'hF00, 32'h0, "R5 test control read");
    rd(32'hF04, 32'h0, "R5 test output read");
    rd(32'h044, 32'h0, "R6 unmapped 0x44");
    rd(32'h800, 32'h0, "R6 unmapped 0x800");
    rd(32'h01C, 32'h0, "R6 unmapped slot word");

    wr(32'h020, 32'd5);
    wr(32'h028, 32'hE0);
    wr(32'h000, 32'd3);
    wr(32'h008, 32'hE0);
    @(negedge clk);
    chk({31'd0, rsp_valid}, 32'd0, "R9 no response after write");
    rd(32'h018, 32'd3,  "R1 timer0 load via 0x18");
    rd(32'h038, 32'd5,  "R2 timer1 load via 0x38");
    rd(32'h024, 32'd5,  "R2 timer1 count via 0x24");
    rd(32'h028, 32'hE0, "R2 timer1 control via 0x28");

    wr(32'h048, 32'h0);
    wr(32'h068, 32'h0);
    wr(32'h060, 32'h0);
    wr(32'hF00, 32'h0);
    rd(32'h008, 32'hE0, "R6 timer0 control after high writes");
    rd(32'h028, 32'hE0, "R6 timer1 control after high writes");
    rd(32'h020, 32'd5,  "R5 timer1 load after test word write");

    wr(32'h00A, 32'h0);
    wr(32'h021, 32'h77);
    rd(32'h008, 32'hE0, "R8 control after unaligned write");
    rd(32'h020, 32'd5,  "R8 load after unaligned write");

    rd(32'hFFFF_F008, 32'hE0, "R7 aliased read");
    wr(32'h7000_0018, 32'd4);
    rd(32'h000, 32'd4, "R7 aliased background load");
    rd(32'h004, 32'd3, "R13 background load keeps count");

    pulse(0, 3);
    chk({31'd0, irq}, 32'd0, "R12 no irq before zero step");
    rd(32'h004, 32'd0, "R12 count reached zero");
    pulse(0, 1);
    chk({31'd0, irq}, 32'd1, "R4 irq from timer0");
    rd(32'h004, 32'd4, "R13 periodic reload");
    rd(32'h024, 32'd5, "R10 timer1 unaffected by tick0");
    rd(32'h010, 32'd1, "R12 timer0 raw set");
    rd(32'h014, 32'd1, "R12 timer0 masked set");
    rd(32'h030, 32'd0, "R12 timer1 raw clear");

    wr(32'h008, 32'hC0);
    @(negedge clk);
    chk({31'd0, irq}, 32'd0, "R4 irq masked off");
    rd(32'h014, 32'd0, "R12 masked clear when disabled");
    rd(32'h010, 32'd1, "R12 raw held when disabled");
    wr(32'h00C, 32'h0);
    rd(32'h010, 32'd0, "R12 raw cleared");

    pulse(1, 5);
    chk({31'd0, irq}, 32'd0, "R4 no irq before timer1 zero step");
    pulse(1, 1);
    chk({31'd0, irq}, 32'd1, "R4 irq from timer1");
    rd(32'h030, 32'd1, "R12 timer1 raw set");
    rd(32'h004, 32'd4, "R10 timer0 unaffected by tick1");

    repeat (3) @(negedge clk);
    chk(32'(exp_q.size()), 32'd0, "R9 all reads answered");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule